// File: doc/BRIEF.md
# Missing Clock Detector

This block watches a monitored system clock from a second, free-running reference clock. It requests a chip reset when the system clock stops. A single flop in the system domain inverts on every system clock edge. The reference domain brings that bit across through a synchronizer chain and treats every change it sees as proof that the system clock is alive.

Each sign of life restarts a retriggerable one-shot counter. If the counter reaches its limit with no activity in between, the block raises a level reset request. In the same reference cycle it emits a one-cycle pulse, which the reset controller uses to record the detector as the reset cause. The detector never drives the external reset pin.

An arm input, taken from a bit of the oscillator control register, enables the detector. The arm input is synchronized into the reference domain. The counter limit is derived from the reference clock frequency in kHz and the timeout in microseconds, rounded up. As a result, the real timeout is never shorter than asked. The default is at least 100 microseconds.

Top module: `clkmon_top`

## Requirements
- R1: After a reference reset, `rst_req` and `cause_pulse` read 0. A reference reset asserted while a request is active clears `rst_req` by the next reference edge.
- R2: While `arm_en` is 0, `rst_req` stays 0 however long the system clock is stopped.
- R3: While armed, a running system clock keeps `rst_req` at 0 indefinitely. Stalls shorter than the timeout (half of it, repeatedly) also leave it at 0.
- R4: The limit is LIMIT = ceil(REF_KHZ * TIMEOUT_US / 1000) reference cycles. When the system clock stops while armed, `rst_req` rises no sooner than LIMIT-1 and no later than LIMIT+6 reference cycles after the stop.
- R5: `cause_pulse` is 1 for exactly one reference cycle, the cycle in which `rst_req` goes from 0 to 1, and 0 at every other time.
- R6: Once raised, `rst_req` stays 1 for as long as the system clock remains absent and the detector stays armed, with no further pulse.
- R7: When the system clock resumes, `rst_req` returns to 0 within 8 reference cycles.
- R8: Dropping `arm_en` clears an active `rst_req` within 5 reference cycles.
- R9: Arming with the system clock already stopped starts the count from zero. `rst_req` rises no sooner than LIMIT reference cycles after `arm_en` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| sys_clk | input | 1 | Monitored system clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| arm_en | input | 1 | Detector enable from the oscillator control register |
| rst_req | output | 1 | Level reset request while the system clock is deemed lost |
| cause_pulse | output | 1 | One reference-cycle pulse as the request is raised |

## Verification
The system clock is asynchronous to the reference clock, so each result is due inside a window rather than on a single cycle. A request is due LIMIT-1 to LIMIT+6 reference cycles after the clock stops, or LIMIT to LIMIT+5 cycles after arming. It falls 1 to 8 cycles after the clock resumes, 1 to 5 after disarming, and 1 to 2 after reset. Each stimulus task stamps the current reference cycle into a queued expectation together with its window. A monitor that samples on the falling reference edge pops the expectation at the first change of `rst_req` and checks the latency. Any change or pulse that is not expected is reported.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    // Detector state in the reference domain
    typedef enum logic [1:0] {
        MCD_OFF   = 2'd0,
        MCD_WATCH = 2'd1,
        MCD_FIRED = 2'd2
    } mcd_state_e;

    localparam int MCD_MIN_STAGES = 2;

    // Reference cycles for the timeout, rounded up, never below one
    function automatic int calc_limit(input int ref_khz, input int timeout_us);
        int cyc;
        cyc = (ref_khz * timeout_us + 999) / 1000;
        return (cyc < 1) ? 1 : cyc;
    endfunction

endpackage

// File: rtl/mcd_toggle_gen.sv
module mcd_toggle_gen (
    input  logic sys_clk,
    input  logic sys_rst,
    output logic tog
);
    // Inverts on every monitored edge; its changes prove the clock runs
    always_ff @(posedge sys_clk) begin
        if (sys_rst) tog <= 1'b0;
        else         tog <= ~tog;
    end
endmodule

// File: rtl/mcd_sync.sv
module mcd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int N = (STAGES < mcd_pkg::MCD_MIN_STAGES) ? mcd_pkg::MCD_MIN_STAGES : STAGES;

    logic [N-1:0] chain;

    for (genvar i = 0; i < N; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)         chain[i] <= RST_VAL;
            else if (i == 0) chain[i] <= d;
            else             chain[i] <= chain[(i == 0) ? 0 : i-1];
        end
    end

    assign q = chain[N-1];
endmodule

// File: rtl/mcd_oneshot.sv
module mcd_oneshot
    import mcd_pkg::*;
#(
    parameter int LIMIT = 12500
) (
    input  logic clk,
    input  logic rst,
    input  logic en_s,
    input  logic tog_s,
    output logic rst_req,
    output logic cause_pulse
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    mcd_state_e     st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           tog_d;
    logic           act;
    logic           pulse_q;

    // Any change of the synchronized toggle is activity
    always_ff @(posedge clk) begin
        if (rst) tog_d <= 1'b0;
        else     tog_d <= tog_s;
    end
    assign act = tog_s ^ tog_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!en_s) begin
            st_d  = MCD_OFF;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                MCD_OFF: begin
                    st_d  = MCD_WATCH;
                    cnt_d = '0;
                end
                MCD_WATCH: begin
                    if (act) begin
                        cnt_d = '0;
                    end else if (cnt_q == LAST) begin
                        st_d = MCD_FIRED;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                MCD_FIRED: begin
                    if (act) begin
                        st_d  = MCD_WATCH;
                        cnt_d = '0;
                    end
                end
                default: begin
                    st_d  = MCD_OFF;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= MCD_OFF;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            pulse_q <= (st_q != MCD_FIRED) && (st_d == MCD_FIRED);
        end
    end

    assign rst_req     = (st_q == MCD_FIRED);
    assign cause_pulse = pulse_q;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST) else $error("count past limit");                   // R4
    AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !en_s |=> !rst_req) else $error("request while disarmed");        // R8
    AST_ACTIVITY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        act |=> !rst_req) else $error("request despite activity");        // R7
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cause_pulse |=> !cause_pulse) else $error("pulse too long");      // R5
    AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> cause_pulse) else $error("rise without pulse"); // R5
endmodule

// File: rtl/clkmon_top.sv
module clkmon_top
    import mcd_pkg::*;
#(
    parameter int REF_KHZ     = 125000,
    parameter int TIMEOUT_US  = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic ref_rst,
    input  logic sys_clk,
    input  logic sys_rst,
    input  logic arm_en,
    output logic rst_req,
    output logic cause_pulse
);
    localparam int LIMIT = calc_limit(REF_KHZ, TIMEOUT_US);

    logic tog_sys;
    logic tog_ref;
    logic en_ref;

    mcd_toggle_gen u_tog (
        .sys_clk (sys_clk),
        .sys_rst (sys_rst),
        .tog     (tog_sys)
    );

    mcd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_tog (
        .clk (ref_clk),
        .rst (ref_rst),
        .d   (tog_sys),
        .q   (tog_ref)
    );

    mcd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_en (
        .clk (ref_clk),
        .rst (ref_rst),
        .d   (arm_en),
        .q   (en_ref)
    );

    mcd_oneshot #(.LIMIT(LIMIT)) u_shot (
        .clk         (ref_clk),
        .rst         (ref_rst),
        .en_s        (en_ref),
        .tog_s       (tog_ref),
        .rst_req     (rst_req),
        .cause_pulse (cause_pulse)
    );

    AST_RESET_QUIET: assert property (@(posedge ref_clk)
        ref_rst |=> !rst_req && !cause_pulse) else $error("outputs live in reset"); // R1
endmodule

// File: tb/tb_clkmon_top.sv
module tb_clkmon_top;

    localparam int REF_KHZ = 125000;
    localparam int TMO_US  = 2;
    localparam int L       = (REF_KHZ * TMO_US + 999) / 1000;  // 250

    logic ref_clk = 1'b0;
    logic sys_clk = 1'b0;
    logic ref_rst = 1'b1;
    logic sys_rst = 1'b1;
    logic arm_en  = 1'b0;
    logic sys_run = 1'b1;
    logic rst_req, cause_pulse;

    int checks = 0;
    int fails  = 0;
    int ref_cyc = 0;
    int pulses  = 0;
    bit mon_on  = 1'b0;
    bit done    = 1'b0;
    logic prev_req = 1'b0;

    typedef struct {
        logic  val;
        int    lo;
        int    hi;
        int    t0;
        string tag;
    } exp_t;
    exp_t q[$];

    clkmon_top #(.REF_KHZ(REF_KHZ), .TIMEOUT_US(TMO_US), .SYNC_STAGES(2)) dut (
        .ref_clk     (ref_clk),
        .ref_rst     (ref_rst),
        .sys_clk     (sys_clk),
        .sys_rst     (sys_rst),
        .arm_en      (arm_en),
        .rst_req     (rst_req),
        .cause_pulse (cause_pulse)
    );

    always #4 ref_clk = ~ref_clk;               // 125 MHz reference
    always begin
        #5;
        if (sys_run) sys_clk = ~sys_clk;        // 100 MHz monitored clock when running
    end
    always @(posedge ref_clk) ref_cyc <= ref_cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, ref_cyc);
        end
    endtask

    // Driver side: queue an expected change of rst_req with its latency window
    task automatic expect_change(input logic v, input int lo, input int hi, input string tag);
        exp_t e;
        e.val = v; e.lo = lo; e.hi = hi; e.t0 = ref_cyc; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wait_drained(input int max_cyc, input string tag);
        int n = 0;
        while (q.size() != 0 && n < max_cyc) begin
            @(negedge ref_clk);
            n++;
        end
        if (q.size() != 0) begin
            check(1'b0, tag, 0, 1);
            q.delete();
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge ref_clk);
    endtask

    // Monitor: compares each change of rst_req against the queue
    always @(negedge ref_clk) begin
        if (mon_on) begin
            if (cause_pulse === 1'b1) pulses++;
            if (rst_req !== prev_req) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2/R3/R6 unexpected change", int'(rst_req), int'(prev_req));
                end else begin
                    exp_t e;
                    int lat;
                    e = q.pop_front();
                    lat = ref_cyc - e.t0;
                    check(rst_req === e.val, e.tag, int'(rst_req), int'(e.val));
                    check(lat >= e.lo && lat <= e.hi, {e.tag, " latency"}, lat, e.lo);
                    if (e.val === 1'b1)
                        check(cause_pulse === 1'b1, "R5 pulse with rise", int'(cause_pulse), 1);
                end
            end else if (cause_pulse === 1'b1) begin
                check(1'b0, "R5 stray pulse", 1, 0);
            end
            prev_req = rst_req;
        end
    end

    initial begin
        idle(10);
        ref_rst = 1'b0;
        sys_rst = 1'b0;
        idle(2);
        check(rst_req === 1'b0, "R1 reset req", int'(rst_req), 0);
        check(cause_pulse === 1'b0, "R1 reset pulse", int'(cause_pulse), 0);
        prev_req = rst_req;
        mon_on = 1'b1;

        // R2: disarmed, clock stopped for a long time
        sys_run = 1'b0;
        idle(3 * L);
        check(rst_req === 1'b0, "R2 disarmed", int'(rst_req), 0);

        // R3: armed with running clock
        sys_run = 1'b1;
        arm_en  = 1'b1;
        idle(3 * L);
        check(rst_req === 1'b0, "R3 running", int'(rst_req), 0);

        // R3: stalls of half the timeout
        for (int k = 0; k < 4; k++) begin
            sys_run = 1'b0;
            idle(L / 2);
            sys_run = 1'b1;
            idle(10);
        end
        check(rst_req === 1'b0, "R3 short stalls", int'(rst_req), 0);

        // R4: stop the clock
        sys_run = 1'b0;
        expect_change(1'b1, L - 1, L + 6, "R4 timeout");
        wait_drained(L + 20, "R4 no request");

        // R6: stays raised, single pulse
        idle(2 * L);
        check(rst_req === 1'b1, "R6 held", int'(rst_req), 1);
        check(pulses == 1, "R6 one pulse", pulses, 1);

        // R7: clock resumes
        sys_run = 1'b1;
        expect_change(1'b0, 1, 8, "R7 recovery");
        wait_drained(20, "R7 no release");

        // R5: second loss gives a second single pulse
        sys_run = 1'b0;
        expect_change(1'b1, L - 1, L + 6, "R4 second timeout");
        wait_drained(L + 20, "R4 no second request");
        idle(3);
        check(pulses == 2, "R5 pulse count", pulses, 2);

        // R8: disarm clears
        arm_en = 1'b0;
        expect_change(1'b0, 1, 5, "R8 disarm");
        wait_drained(20, "R8 no release");
        idle(2 * L);
        check(rst_req === 1'b0, "R8 stays clear", int'(rst_req), 0);

        // R9: arming with clock stopped counts from zero
        arm_en = 1'b1;
        expect_change(1'b1, L, L + 5, "R9 fresh count");
        wait_drained(L + 20, "R9 no request");

        // R1: reset clears an active request
        ref_rst = 1'b1;
        expect_change(1'b0, 1, 2, "R1 reset clears");
        wait_drained(10, "R1 no clear");
        idle(3);
        check(rst_req === 1'b0 && cause_pulse === 1'b0, "R1 in reset",
              int'(rst_req), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule